// File: doc/BRIEF.md
# Quadtree Partition Mode Decision with Best-Candidate Tracking

This block sits behind a pair of SAD engines in an integer motion search for a 32x32 coding block. On every accepted transfer it receives two candidate SAD vectors, each with a motion-vector tag. Every vector covers all 105 partitions of the three-level quadtree: one 32x32 root, four 16x16 blocks and sixteen 8x8 blocks, with five partition SADs per block. For each partition the block keeps the lowest SAD seen so far and the motion vector that produced it.

When the search engine raises `search_done`, intake stops and a serial decision runs, one block per cycle. Each 8x8 block is evaluated first, then each 16x16 block, then the root. For every block the cheapest of three partition modes is chosen. A block is split when the sum of its four children's costs is strictly lower than its own best cost. After the decision, a one-cycle `dec_done` pulse presents the split flags, the mode of every block, the root's total cost and the winning motion vectors. The partition cost is the SAD plus the constant `PCOST`.

The candidate input is a valid/ready stream. A transfer happens only in a cycle where both `cand_valid` and `cand_ready` are high. `cand_ready` is low from the cycle after `search_done` is accepted until the cycle after the `dec_done` pulse. During that time the source must hold its data. Anything it presents while `cand_ready` is low has no effect.

Top module: `qt_mode_decide`

## Requirements
- R1: Each input vector is laid out as entry e = 5*b + p, where entry e occupies bits [16e+15:16e] of the default 16-bit field. Block b is 0 for the root, 1+i for 16x16 block i, and 5+k for 8x8 block k. 8x8 block k belongs to 16x16 block k/4. The partition p is 0 for whole, 1 for top half, 2 for bottom half, 3 for left half and 4 for right half.
- R2: Within one transfer, the lower of the two SADs for an entry is the pair's winner. On equal SADs, candidate A wins.
- R3: A pair winner replaces the stored minimum and its motion vector only when its SAD is strictly lower. On equal SADs, the earlier candidate is kept. `best_mv` presents the stored motion vectors.
- R4: A candidate is taken only in a cycle where both `cand_valid` and `cand_ready` are high. Input presented while `cand_ready` is low leaves every stored minimum unchanged.
- R5: `search_done` is accepted only while `cand_ready` is high, and `cand_ready` is low in the next cycle. A candidate transferred in the same cycle as `search_done` takes part in the decision.
- R6: Each block's mode costs are computed as follows. Whole is SAD+PCOST. Horizontal (top+bottom) is the sum of the two SADs plus 2*PCOST. Vertical (left+right) is the sum of the two SADs plus 2*PCOST. The lowest cost wins. Ties go in the order whole, then horizontal, then vertical. The mode codes are 0 for whole, 1 for horizontal and 2 for vertical. `mode8[2k+1:2k]` holds 8x8 block k and `mode16[2i+1:2i]` holds 16x16 block i.
- R7: A 16x16 block sets `split16[i]` and takes the sum of its four 8x8 costs only when that sum is strictly lower than its own best mode cost. Otherwise it keeps its own cost.
- R8: `split_root` is set when the sum of the four 16x16 costs is strictly lower than the root's best mode cost. `total_cost` is the lower of the two.
- R9: `dec_done` is high for exactly one cycle: the 22nd cycle after the cycle in which `search_done` is accepted.
- R10: After the `dec_done` cycle, and after reset, every stored minimum SAD is all ones and every stored motion vector is zero. A search with no candidates therefore decides on all-ones SADs.
- R11: After reset, `cand_ready` is 1, `dec_done` is 0, and the decision outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cand_valid | input | 1 | A candidate pair is presented |
| cand_ready | output | 1 | Candidates are accepted (collecting phase) |
| cand_sad_a | input | 105*SADW | Partition SADs of candidate A |
| cand_sad_b | input | 105*SADW | Partition SADs of candidate B |
| cand_mv_a | input | MVW | Motion vector tag of candidate A |
| cand_mv_b | input | MVW | Motion vector tag of candidate B |
| search_done | input | 1 | End of search; starts the decision |
| dec_done | output | 1 | One-cycle pulse, decision outputs valid |
| split_root | output | 1 | Root split into four 16x16 blocks |
| split16 | output | 4 | Split flag per 16x16 block |
| root_mode | output | 2 | Best mode of the root |
| mode16 | output | 8 | Best mode per 16x16 block |
| mode8 | output | 32 | Best mode per 8x8 block |
| total_cost | output | CW | Cost of the chosen root decision |
| best_mv | output | 105*MVW | Winning motion vector per entry |

## Verification
Some behaviours are checked by assertions on every cycle. Stored minima never rise while collecting. They are frozen while intake is stalled and return to all ones after the done pulse. Accepting `search_done` drops `cand_ready` at once, and `dec_done` never lasts two cycles. Other behaviours can only be shown by the bench's scenarios, run against its behavioural model. These are the choice of pair winner and running minimum on ties, the mode tie order, the strict split rule at both levels, the exact 22-cycle latency, and the empty-search case with all-ones costs.

// File: rtl/qtmd_pkg.sv
package qtmd_pkg;
  // quadtree layout: 1 root + 4 mid + 16 leaf blocks, five partitions each
  localparam int NPB      = 5;
  localparam int N16      = 4;
  localparam int N8       = 16;
  localparam int NBLK     = 1 + N16 + N8;
  localparam int NENT     = NBLK * NPB;
  localparam int B16_BASE = 1;
  localparam int B8_BASE  = 1 + N16;

  typedef enum logic [1:0] {
    MD_WHOLE = 2'd0,
    MD_HOR   = 2'd1,
    MD_VER   = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAF, ST_MID, ST_ROOT, ST_DONE
  } phase_e;
endpackage

// File: rtl/qtmd_min_track.sv
module qtmd_min_track #(
  parameter int SADW = 16,
  parameter int MVW  = 16,
  parameter int NENT = 105
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic [NENT*SADW-1:0] sad_a,
  input  logic [NENT*SADW-1:0] sad_b,
  input  logic [MVW-1:0]       mv_a,
  input  logic [MVW-1:0]       mv_b,
  output logic [NENT*SADW-1:0] min_sad,
  output logic [NENT*MVW-1:0]  min_mv
);
  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic [SADW-1:0] sa, sb, pair_sad, cur;
    logic [MVW-1:0]  pair_mv;
    assign sa       = sad_a[e*SADW +: SADW];
    assign sb       = sad_b[e*SADW +: SADW];
    assign pair_sad = (sb < sa) ? sb : sa;
    assign pair_mv  = (sb < sa) ? mv_b : mv_a;
    assign cur      = min_sad[e*SADW +: SADW];

    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        min_sad[e*SADW +: SADW] <= '1;
        min_mv[e*MVW +: MVW]    <= '0;
      end else if (upd && (pair_sad < cur)) begin
        min_sad[e*SADW +: SADW] <= pair_sad;
        min_mv[e*MVW +: MVW]    <= pair_mv;
      end
    end
  end
endmodule

// File: rtl/qtmd_mode_pick.sv
module qtmd_mode_pick #(
  parameter int SADW  = 16,
  parameter int CW    = 22,
  parameter int PCOST = 64
) (
  input  logic [SADW-1:0]   s_whole,
  input  logic [SADW-1:0]   s_top,
  input  logic [SADW-1:0]   s_bot,
  input  logic [SADW-1:0]   s_left,
  input  logic [SADW-1:0]   s_right,
  output logic [CW-1:0]     cost,
  output qtmd_pkg::mode_e   mode
);
  localparam logic [CW-1:0] P1 = CW'(PCOST);
  localparam logic [CW-1:0] P2 = CW'(2 * PCOST);

  logic [CW-1:0] c_w, c_h, c_v;
  assign c_w = CW'(s_whole) + P1;
  assign c_h = CW'(s_top) + CW'(s_bot) + P2;
  assign c_v = CW'(s_left) + CW'(s_right) + P2;

  always_comb begin
    if (c_w <= c_h && c_w <= c_v) begin
      cost = c_w;
      mode = qtmd_pkg::MD_WHOLE;
    end else if (c_h <= c_v) begin
      cost = c_h;
      mode = qtmd_pkg::MD_HOR;
    end else begin
      cost = c_v;
      mode = qtmd_pkg::MD_VER;
    end
  end
endmodule

// File: rtl/qtmd_sum4.sv
module qtmd_sum4 #(
  parameter int CW = 22
) (
  input  logic [CW-1:0] c0,
  input  logic [CW-1:0] c1,
  input  logic [CW-1:0] c2,
  input  logic [CW-1:0] c3,
  output logic [CW-1:0] sum
);
  logic [CW-1:0] lo, hi;
  assign lo  = c0 + c1;
  assign hi  = c2 + c3;
  assign sum = lo + hi;
endmodule

// File: rtl/qt_mode_decide.sv
module qt_mode_decide #(
  parameter int SADW  = 16,
  parameter int MVW   = 16,
  parameter int PCOST = 64,
  parameter int CW    = SADW + 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cand_valid,
  output logic                             cand_ready,
  input  logic [qtmd_pkg::NENT*SADW-1:0]   cand_sad_a,
  input  logic [qtmd_pkg::NENT*SADW-1:0]   cand_sad_b,
  input  logic [MVW-1:0]                   cand_mv_a,
  input  logic [MVW-1:0]                   cand_mv_b,
  input  logic                             search_done,
  output logic                             dec_done,
  output logic                             split_root,
  output logic [qtmd_pkg::N16-1:0]         split16,
  output logic [1:0]                       root_mode,
  output logic [2*qtmd_pkg::N16-1:0]       mode16,
  output logic [2*qtmd_pkg::N8-1:0]        mode8,
  output logic [CW-1:0]                    total_cost,
  output logic [qtmd_pkg::NENT*MVW-1:0]    best_mv
);
  import qtmd_pkg::*;

  localparam int IDXW = $clog2(N8);

  phase_e              state;
  logic [IDXW-1:0]     idx;
  logic [NENT*SADW-1:0] min_sad;
  logic [CW-1:0]       bank8  [N8];
  logic [CW-1:0]       bank16 [N16];
  logic [SADW-1:0]     ps [NPB];
  logic [4:0]          blk_sel;
  logic [CW-1:0]       pick_cost, leaf_sum, mid_sum;
  mode_e               pick_mode;
  logic [CW-1:0]       leaf_in [4];

  assign cand_ready = (state == ST_IDLE);
  assign dec_done   = (state == ST_DONE);

  qtmd_min_track #(.SADW(SADW), .MVW(MVW), .NENT(NENT)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_DONE),
    .upd(cand_valid && cand_ready),
    .sad_a(cand_sad_a), .sad_b(cand_sad_b),
    .mv_a(cand_mv_a), .mv_b(cand_mv_b),
    .min_sad(min_sad), .min_mv(best_mv)
  );

  // one block is evaluated per cycle; the state picks which
  always_comb begin
    case (state)
      ST_LEAF: blk_sel = 5'(B8_BASE) + 5'(idx);
      ST_MID:  blk_sel = 5'(B16_BASE) + 5'(idx[1:0]);
      default: blk_sel = 5'd0;
    endcase
  end

  always_comb begin
    for (int p = 0; p < NPB; p++)
      ps[p] = min_sad[(int'(blk_sel) * NPB + p) * SADW +: SADW];
  end

  qtmd_mode_pick #(.SADW(SADW), .CW(CW), .PCOST(PCOST)) u_pick (
    .s_whole(ps[0]), .s_top(ps[1]), .s_bot(ps[2]),
    .s_left(ps[3]), .s_right(ps[4]),
    .cost(pick_cost), .mode(pick_mode)
  );

  for (genvar k = 0; k < 4; k++) begin : g_leaf_in
    assign leaf_in[k] = bank8[{idx[1:0], 2'(k)}];
  end

  qtmd_sum4 #(.CW(CW)) u_leaf_sum (
    .c0(leaf_in[0]), .c1(leaf_in[1]), .c2(leaf_in[2]), .c3(leaf_in[3]),
    .sum(leaf_sum)
  );

  qtmd_sum4 #(.CW(CW)) u_mid_sum (
    .c0(bank16[0]), .c1(bank16[1]), .c2(bank16[2]), .c3(bank16[3]),
    .sum(mid_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (search_done) begin
          state <= ST_LEAF;
          idx   <= '0;
        end
        ST_LEAF: begin
          idx <= idx + 1'b1;
          if (idx == IDXW'(N8 - 1)) state <= ST_MID;
        end
        ST_MID: begin
          idx <= idx + 1'b1;
          if (idx[1:0] == 2'(N16 - 1)) state <= ST_ROOT;
        end
        ST_ROOT: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N8; k++) bank8[k] <= '0;
      for (int k = 0; k < N16; k++) bank16[k] <= '0;
      mode8      <= '0;
      mode16     <= '0;
      split16    <= '0;
      root_mode  <= '0;
      split_root <= 1'b0;
      total_cost <= '0;
    end else begin
      case (state)
        ST_LEAF: begin
          bank8[idx]         <= pick_cost;
          mode8[idx*2 +: 2]  <= pick_mode;
        end
        ST_MID: begin
          bank16[idx[1:0]]        <= (leaf_sum < pick_cost) ? leaf_sum : pick_cost;
          split16[idx[1:0]]       <= (leaf_sum < pick_cost);
          mode16[idx[1:0]*2 +: 2] <= pick_mode;
        end
        ST_ROOT: begin
          total_cost <= (mid_sum < pick_cost) ? mid_sum : pick_cost;
          split_root <= (mid_sum < pick_cost);
          root_mode  <= pick_mode;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qt_mode_decide_chk.sv
module qt_mode_decide_chk #(
  parameter int SADW = 16,
  parameter int NENT = 105
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cand_ready,
  input logic                 search_done,
  input logic                 dec_done,
  input logic [NENT*SADW-1:0] min_sad
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> !dec_done); // R9
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_ready && search_done) |=> !cand_ready); // R5
  AST_MIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_ready && $past(cand_ready)) |-> (min_sad[SADW-1:0] <= $past(min_sad[SADW-1:0]))); // R3
  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cand_ready && !dec_done) |=> $stable(min_sad)); // R4
  AST_MIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |=> (min_sad == '1)); // R10
endmodule

bind qt_mode_decide qt_mode_decide_chk #(.SADW(SADW), .NENT(qtmd_pkg::NENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_ready(cand_ready),
  .search_done(search_done), .dec_done(dec_done), .min_sad(min_sad)
);

// File: tb/test_qt_mode_decide.sv
module test_qt_mode_decide;
  localparam int SADW = 16, MVW = 16, PC = 64, CW = 22, NENT = 105;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cand_valid = 1'b0, search_done = 1'b0;
  logic [NENT*SADW-1:0] sad_a = '0, sad_b = '0;
  logic [MVW-1:0] mv_a = '0, mv_b = '0;
  logic cand_ready, dec_done, split_root;
  logic [3:0] split16;
  logic [1:0] root_mode;
  logic [7:0] mode16;
  logic [31:0] mode8;
  logic [CW-1:0] total_cost;
  logic [NENT*MVW-1:0] best_mv;

  always #2 clk = ~clk;

  qt_mode_decide #(.SADW(SADW), .MVW(MVW), .PCOST(PC), .CW(CW)) i_qt_mode_decide (
    .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_sad_a(sad_a), .cand_sad_b(sad_b), .cand_mv_a(mv_a), .cand_mv_b(mv_b),
    .search_done(search_done), .dec_done(dec_done), .split_root(split_root),
    .split16(split16), .root_mode(root_mode), .mode16(mode16), .mode8(mode8),
    .total_cost(total_cost), .best_mv(best_mv)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference
  int m_sad [NENT];
  int m_mv  [NENT];
  int phase = 0;
  int e_total, e_split_root, e_root_mode;
  logic [3:0]  e_split16;
  logic [7:0]  e_mode16;
  logic [31:0] e_mode8;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void best_of_block(input int b, output int cost, output int mode);
    int cw, ch, cv;
    cw = m_sad[b*5] + PC;
    ch = m_sad[b*5+1] + m_sad[b*5+2] + 2*PC;
    cv = m_sad[b*5+3] + m_sad[b*5+4] + 2*PC;
    if (cw <= ch && cw <= cv) begin cost = cw; mode = 0; end
    else if (ch <= cv) begin cost = ch; mode = 1; end
    else begin cost = cv; mode = 2; end
  endfunction

  task automatic compute_expected();
    int leaf [16];
    int mid [4];
    int c, m, s;
    for (int k = 0; k < 16; k++) begin
      best_of_block(5 + k, c, m);
      leaf[k] = c;
      e_mode8[2*k +: 2] = 2'(m);
    end
    for (int i = 0; i < 4; i++) begin
      best_of_block(1 + i, c, m);
      s = leaf[4*i] + leaf[4*i+1] + leaf[4*i+2] + leaf[4*i+3];
      e_mode16[2*i +: 2] = 2'(m);
      e_split16[i] = (s < c);
      mid[i] = (s < c) ? s : c;
    end
    best_of_block(0, c, m);
    s = mid[0] + mid[1] + mid[2] + mid[3];
    e_root_mode = m;
    e_split_root = (s < c) ? 1 : 0;
    e_total = (s < c) ? s : c;
  endtask

  task automatic clear_model();
    for (int e = 0; e < NENT; e++) begin
      m_sad[e] = 65535;
      m_mv[e] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      clear_model();
      phase = 0;
    end else if (phase == 0) begin
      if (cand_valid) begin
        for (int e = 0; e < NENT; e++) begin
          int a, b, ps, pm;
          a = int'(sad_a[e*SADW +: SADW]);
          b = int'(sad_b[e*SADW +: SADW]);
          ps = (b < a) ? b : a;
          pm = (b < a) ? int'(mv_b) : int'(mv_a);
          if (ps < m_sad[e]) begin m_sad[e] = ps; m_mv[e] = pm; end
        end
      end
      if (search_done) begin
        compute_expected();
        phase = 1;
      end
    end else if (phase == 22) begin
      clear_model();
      phase = 0;
    end else begin
      phase++;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4", "cand_ready", cand_ready, phase == 0);
      chk("R9", "dec_done", dec_done, phase == 22);
      if (phase == 22) begin
        logic [NENT*MVW-1:0] emv;
        for (int e = 0; e < NENT; e++) emv[e*MVW +: MVW] = MVW'(m_mv[e]);
        chk("R8", "total_cost", total_cost, e_total);
        chk("R8", "split_root", split_root, e_split_root);
        chk("R7", "split16", split16, e_split16);
        chk("R6", "root_mode", root_mode, e_root_mode);
        chk("R6", "mode16", mode16, e_mode16);
        chk("R6", "mode8", mode8, e_mode8);
        n_tests++;
        if (best_mv !== emv) begin
          n_fail++;
          $display("FAIL R3 best_mv: actual %h expected %h", best_mv, emv);
        end
      end
    end
  end

  function automatic int pick_sad(input int sc, input int e);
    int leafish;
    leafish = (e / 5) >= 5;
    case (sc)
      1: return $urandom_range(7, 0);
      2: return leafish ? $urandom_range(15, 0) : $urandom_range(8000, 4000);
      3: return leafish ? $urandom_range(4000, 3000) : $urandom_range(50, 0);
      default: return $urandom_range(1023, 0);
    endcase
  endfunction

  task automatic fill(input int sc, input bit tie);
    for (int e = 0; e < NENT; e++) begin
      sad_a[e*SADW +: SADW] = SADW'(pick_sad(sc, e));
      sad_b[e*SADW +: SADW] = tie ? sad_a[e*SADW +: SADW] : SADW'(pick_sad(sc, e));
    end
  endtask

  int mv_base = 16;

  // R1 layout, R2/R3 compare, R5 done with last pair, R4 stall input ignored
  task automatic run_round(input int sc, input int npairs, input bit done_last, input bit tie);
    for (int p = 0; p < npairs; p++) begin
      @(negedge clk);
      cand_valid = (p % 5 != 3) || (done_last && p == npairs - 1);
      fill(sc, tie && (p % 2 == 0));
      mv_a = MVW'(mv_base + 2*p);
      mv_b = MVW'(mv_base + 2*p + 1);
      search_done = done_last && (p == npairs - 1);
    end
    if (!(done_last && npairs > 0)) begin
      @(negedge clk);
      cand_valid = 1'b0;
      search_done = 1'b1;
    end
    @(negedge clk);
    search_done = 1'b0;
    for (int g = 0; g < 5; g++) begin
      cand_valid = 1'b1;
      for (int e = 0; e < NENT; e++) begin
        sad_a[e*SADW +: SADW] = '0;
        sad_b[e*SADW +: SADW] = '0;
      end
      mv_a = 16'hDEAD;
      mv_b = 16'hBEEF;
      @(negedge clk);
    end
    cand_valid = 1'b0;
    while (phase != 0) @(negedge clk);
    mv_base += 256;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual hang expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11", "reset cand_ready", cand_ready, 1);
    chk("R11", "reset dec_done", dec_done, 0);
    chk("R11", "reset total_cost", total_cost, 0);
    chk("R11", "reset split16", split16, 0);
    run_round(0, 20, 1'b0, 1'b0);  // R2 R3 random search
    run_round(1, 24, 1'b1, 1'b1);  // R2 R3 ties, R5 done with last pair
    run_round(0, 0, 1'b0, 1'b0);   // R10 empty search: all-ones SADs
    run_round(2, 12, 1'b0, 1'b0);  // R7 R8 splits favoured
    run_round(3, 12, 1'b1, 1'b0);  // R7 R8 splits rejected
    run_round(1, 30, 1'b0, 1'b0);  // R6 mode ties
    repeat (3) @(negedge clk);
    summary();
  end
endmodule